// File: doc/BRIEF.md
# Character-cell raster address generator

This block follows the beam of a video raster in units of display-clock cycles and horizontal scan lines and maps it onto a text grid of 24 columns by 12 rows, each cell 12 dots wide and 18 scan lines tall. For every clock it reports the display-RAM address of the cell under the beam, the dot column and scan row inside that cell, and a flag that is high only while the beam is over a text cell. A character-pattern store and a pixel serializer downstream use these outputs; this block neither holds nor draws characters.

The text window is placed by a 10-bit horizontal start value and a 10-bit vertical start value. Its horizontal offset also depends on the horizontal size code. Each dot can be stretched over 1 to 4 clock cycles and each scan row over 1 to 4 lines. A 3-bit gap code can insert blank bands, each one text row high, between groups of rows. Both sync inputs carry a polarity input and act only on the transition into their asserted level.

Two state machines do the work. The horizontal one has states H_WAIT, H_RUN and H_DONE: a horizontal sync edge forces H_WAIT; H_WAIT moves to H_RUN when the cycle count reaches the start point; H_RUN moves to H_DONE after the last repeat of the last dot of column 24. The vertical one has states V_WAIT, V_TEXT, V_GAP and V_DONE, and changes state only on a horizontal sync edge. A vertical sync edge forces V_WAIT. V_WAIT moves to V_TEXT on the line at the vertical start. At the end of a text row, V_TEXT moves to V_DONE after row 12, to V_GAP if the gap code puts a gap there, and otherwise stays in V_TEXT. V_GAP returns to V_TEXT after its last gap band.

Top module: `cell_raster_addr`

## Requirements
- R1: After reset, disp_active is low and ram_addr, dot_col and scan_row are zero, and they stay so until a vertical and then a horizontal sync edge are seen.
- R2: A sync input is asserted when it equals its polarity input (1 = active high). Only the clock edge at which it first turns asserted restarts counting. Holding it asserted for more cycles has no further effect.
- R3: If the horizontal sync edge is sampled at clock edge E0, the first active cycle begins at edge E(S) with S = h_start + 6 + h_size (h_size code 0..3 gives offsets 6, 7, 8, 9). disp_active is low between E0 and E(S).
- R4: Each dot is held for h_size+1 cycles. dot_col counts 0 to 11 within a column and the column then advances. The line stays active for 288×(h_size+1) cycles and is then low until the next horizontal sync edge.
- R5: The line started by the v_start-th horizontal sync edge after a vertical sync edge is the first scan line of text. Earlier lines are inactive.
- R6: Each text row spans 18×(v_size+1) lines. scan_row counts 0 to 17 and each value is held for v_size+1 lines.
- R7: ram_addr = row×24 + column with both counted from 0, so it runs from 0x000 to 0x11F.
- R8: row_gap_mode places blank bands one text row high: 0 none; k = 1..5 one band after the first k rows and one after the first 12−k rows; 6 one band after row 6; 7 two bands after row 6.
- R9: During a gap band and after the twelfth row, disp_active is low and the row count does not advance. While disp_active is low, ram_addr, dot_col and scan_row read zero.
- R10: A vertical sync edge at any point restarts the frame from row 0, and disp_active is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Active-low reset |
| hsync_in | input | 1 | Horizontal sync |
| vsync_in | input | 1 | Vertical sync |
| hsync_high | input | 1 | Horizontal sync polarity, 1 = active high |
| vsync_high | input | 1 | Vertical sync polarity, 1 = active high |
| h_start | input | 10 | Horizontal start value |
| h_size | input | 2 | Horizontal size code, dot repeat = code+1 |
| v_start | input | 10 | Vertical start value |
| v_size | input | 2 | Vertical size code, line repeat = code+1 |
| row_gap_mode | input | 3 | Blank band placement code |
| disp_active | output | 1 | Beam is over a text cell |
| ram_addr | output | 9 | Display-RAM address of the current cell |
| dot_col | output | 4 | Dot column inside the cell |
| scan_row | output | 5 | Scan row inside the cell |

## Verification
A slipped horizontal counter shows up within one line as a shifted first active cycle, or as a dot_col or ram_addr step that breaks the one-per-repeat pattern. A wrong vertical state or row counter only shows up at the next row boundary: a text row that should have been a gap band, or an address row offset by 24. So the bench checks every cycle of the first text line and one fixed cycle on every line of each frame. The frames cover all eight gap codes, both polarities and all four size codes in each direction. A restart halfway through a frame shows whether the vertical state really returns to row 0.

// File: rtl/cra_pkg.sv
package cra_pkg;

    typedef enum logic [1:0] {
        H_WAIT,
        H_RUN,
        H_DONE
    } hstate_t;

    typedef enum logic [1:0] {
        V_WAIT,
        V_TEXT,
        V_GAP,
        V_DONE
    } vstate_t;

    // Number of blank bands that follow once `done` text rows are complete.
    function automatic logic [1:0] gaps_after(input logic [2:0] code, input int done, input int rows);
        if (code == 3'd0) begin
            return 2'd0;
        end
        if (code[2:1] == 2'b11) begin
            if (done == rows / 2) begin
                return code[0] ? 2'd2 : 2'd1;
            end
            return 2'd0;
        end
        if (done == int'(code) || done == rows - int'(code)) begin
            return 2'd1;
        end
        return 2'd0;
    endfunction

endpackage

// File: rtl/cra_sync_edge.sv
module cra_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic active_high,
    output logic edge_pulse
);
    logic asserted;
    logic asserted_q;

    assign asserted = (sync_in == active_high);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asserted_q <= 1'b0;
        end else begin
            asserted_q <= asserted;
        end
    end

    assign edge_pulse = asserted & ~asserted_q;
endmodule

// File: rtl/cra_hscan.sv
module cra_hscan
    import cra_pkg::*;
#(
    parameter int COLS     = 24,
    parameter int CELL_W   = 12,
    parameter int POS_W    = 10,
    parameter int SIZE_W   = 2,
    parameter int H_OFFSET = 6,
    localparam int CNT_W   = POS_W + 1,
    localparam int COL_W   = $clog2(COLS),
    localparam int DOT_W   = $clog2(CELL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [POS_W-1:0]  h_start,
    input  logic [SIZE_W-1:0] h_size,
    output logic              h_on,
    output logic [COL_W-1:0]  col_o,
    output logic [DOT_W-1:0]  dot_o
);
    hstate_t            st, st_n;
    logic [CNT_W-1:0]   hcnt;
    logic [CNT_W-1:0]   hstart;
    logic [SIZE_W-1:0]  rep;
    logic [DOT_W-1:0]   dot;
    logic [COL_W-1:0]   col;
    logic               rep_last, dot_last, col_last;

    assign hstart   = CNT_W'(h_start) + CNT_W'(H_OFFSET) + CNT_W'(h_size);
    assign rep_last = (rep == h_size);
    assign dot_last = (dot == DOT_W'(CELL_W - 1));
    assign col_last = (col == COL_W'(COLS - 1));

    // Next-state logic
    always_comb begin
        st_n = st;
        unique case (st)
            H_WAIT:  if (hcnt == hstart - 1'b1) st_n = H_RUN;
            H_RUN:   if (rep_last && dot_last && col_last) st_n = H_DONE;
            H_DONE:  st_n = H_DONE;
            default: st_n = H_DONE;
        endcase
        if (line_start) begin
            st_n = H_WAIT;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= H_DONE;
        end else begin
            st <= st_n;
        end
    end

    // Position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
            rep  <= '0;
            dot  <= '0;
            col  <= '0;
        end else if (line_start) begin
            hcnt <= '0;
            rep  <= '0;
            dot  <= '0;
            col  <= '0;
        end else begin
            if (hcnt != '1) begin
                hcnt <= hcnt + 1'b1;
            end
            if (st == H_RUN) begin
                if (rep_last) begin
                    rep <= '0;
                    if (dot_last) begin
                        dot <= '0;
                        col <= col_last ? '0 : col + 1'b1;
                    end else begin
                        dot <= dot + 1'b1;
                    end
                end else begin
                    rep <= rep + 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        h_on  = (st == H_RUN);
        col_o = col;
        dot_o = dot;
    end
endmodule

// File: rtl/cra_vscan.sv
module cra_vscan
    import cra_pkg::*;
#(
    parameter int ROWS    = 12,
    parameter int CELL_H  = 18,
    parameter int POS_W   = 10,
    parameter int SIZE_W  = 2,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int SCAN_W = $clog2(CELL_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic [POS_W-1:0]  v_start,
    input  logic [SIZE_W-1:0] v_size,
    input  logic [2:0]        gap_mode,
    output logic              v_on,
    output logic [ROW_W-1:0]  row_o,
    output logic [SCAN_W-1:0] scan_o
);
    vstate_t            st, st_n;
    logic [POS_W-1:0]   lcnt;
    logic [SIZE_W-1:0]  vrep;
    logic [SCAN_W-1:0]  scan;
    logic [ROW_W-1:0]   row;
    logic [1:0]         gaps_left;
    logic [1:0]         gap_n;
    logic               scan_last, row_end, row_last, start_hit;

    assign scan_last = (scan == SCAN_W'(CELL_H - 1));
    assign row_end   = (vrep == v_size) && scan_last;
    assign row_last  = (row == ROW_W'(ROWS - 1));
    assign start_hit = ({1'b0, lcnt} + 1'b1) == {1'b0, v_start};
    assign gap_n     = gaps_after(gap_mode, int'(row) + 1, ROWS);

    // Next-state logic, advanced once per scan line
    always_comb begin
        st_n = st;
        if (frame_start) begin
            st_n = V_WAIT;
        end else if (line_start) begin
            unique case (st)
                V_WAIT:  if (start_hit) st_n = V_TEXT;
                V_TEXT: begin
                    if (row_end) begin
                        if (row_last)          st_n = V_DONE;
                        else if (gap_n != '0)  st_n = V_GAP;
                        else                   st_n = V_TEXT;
                    end
                end
                V_GAP:   if (row_end && gaps_left == 2'd1) st_n = V_TEXT;
                V_DONE:  st_n = V_DONE;
                default: st_n = V_DONE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= V_DONE;
        end else begin
            st <= st_n;
        end
    end

    // Line, scan and row counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcnt      <= '0;
            vrep      <= '0;
            scan      <= '0;
            row       <= '0;
            gaps_left <= '0;
        end else if (frame_start) begin
            lcnt      <= '0;
            vrep      <= '0;
            scan      <= '0;
            row       <= '0;
            gaps_left <= '0;
        end else if (line_start) begin
            if (lcnt != '1) begin
                lcnt <= lcnt + 1'b1;
            end
            if (st == V_TEXT || st == V_GAP) begin
                if (vrep == v_size) begin
                    vrep <= '0;
                    scan <= scan_last ? '0 : scan + 1'b1;
                end else begin
                    vrep <= vrep + 1'b1;
                end
            end
            if (st == V_TEXT && row_end && !row_last) begin
                row       <= row + 1'b1;
                gaps_left <= gap_n;
            end
            if (st == V_GAP && row_end) begin
                gaps_left <= gaps_left - 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        v_on   = (st == V_TEXT);
        row_o  = row;
        scan_o = scan;
    end
endmodule

// File: rtl/cell_raster_addr.sv
module cell_raster_addr #(
    parameter int COLS     = 24,
    parameter int ROWS     = 12,
    parameter int CELL_W   = 12,
    parameter int CELL_H   = 18,
    parameter int POS_W    = 10,
    parameter int SIZE_W   = 2,
    parameter int H_OFFSET = 6,
    localparam int ADDR_W  = $clog2(COLS * ROWS),
    localparam int COL_W   = $clog2(COLS),
    localparam int ROW_W   = $clog2(ROWS),
    localparam int DOT_W   = $clog2(CELL_W),
    localparam int SCAN_W  = $clog2(CELL_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic              hsync_high,
    input  logic              vsync_high,
    input  logic [POS_W-1:0]  h_start,
    input  logic [SIZE_W-1:0] h_size,
    input  logic [POS_W-1:0]  v_start,
    input  logic [SIZE_W-1:0] v_size,
    input  logic [2:0]        row_gap_mode,
    output logic              disp_active,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DOT_W-1:0]  dot_col,
    output logic [SCAN_W-1:0] scan_row
);
    logic [1:0]        sync_raw, sync_pol, sync_edge;
    logic              h_on, v_on;
    logic [COL_W-1:0]  col;
    logic [DOT_W-1:0]  dot;
    logic [ROW_W-1:0]  row;
    logic [SCAN_W-1:0] scan;

    assign sync_raw = {vsync_in, hsync_in};
    assign sync_pol = {vsync_high, hsync_high};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        cra_sync_edge u_edge (
            .clk        (clk),
            .rst_n      (rst_n),
            .sync_in    (sync_raw[g]),
            .active_high(sync_pol[g]),
            .edge_pulse (sync_edge[g])
        );
    end

    cra_hscan #(
        .COLS(COLS), .CELL_W(CELL_W), .POS_W(POS_W), .SIZE_W(SIZE_W), .H_OFFSET(H_OFFSET)
    ) u_hscan (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_start(sync_edge[0]),
        .h_start   (h_start),
        .h_size    (h_size),
        .h_on      (h_on),
        .col_o     (col),
        .dot_o     (dot)
    );

    cra_vscan #(
        .ROWS(ROWS), .CELL_H(CELL_H), .POS_W(POS_W), .SIZE_W(SIZE_W)
    ) u_vscan (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(sync_edge[1]),
        .line_start (sync_edge[0]),
        .v_start    (v_start),
        .v_size     (v_size),
        .gap_mode   (row_gap_mode),
        .v_on       (v_on),
        .row_o      (row),
        .scan_o     (scan)
    );

    always_comb begin
        disp_active = h_on & v_on;
        if (disp_active) begin
            ram_addr = ADDR_W'(row) * ADDR_W'(COLS) + ADDR_W'(col);
            dot_col  = dot;
            scan_row = scan;
        end else begin
            ram_addr = '0;
            dot_col  = '0;
            scan_row = '0;
        end
    end
endmodule

// File: rtl/cra_checker.sv
module cra_checker #(
    parameter int COLS   = 24,
    parameter int ROWS   = 12,
    parameter int CELL_W = 12,
    parameter int CELL_H = 18,
    parameter int ADDR_W = 9,
    parameter int DOT_W  = 4,
    parameter int SCAN_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hsync_in,
    input logic              vsync_in,
    input logic              hsync_high,
    input logic              vsync_high,
    input logic              disp_active,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [DOT_W-1:0]  dot_col,
    input logic [SCAN_W-1:0] scan_row
);
    assert_addr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        disp_active |-> (int'(ram_addr) < COLS * ROWS));

    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_active && $past(disp_active)) |->
            (ram_addr == $past(ram_addr) || ram_addr == $past(ram_addr) + 1'b1));

    assert_dotcol_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        disp_active |-> (int'(dot_col) < CELL_W));

    assert_dotcol_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_active && $past(disp_active)) |->
            (dot_col == $past(dot_col) || dot_col == $past(dot_col) + 1'b1 ||
             (dot_col == '0 && $past(dot_col) == DOT_W'(CELL_W - 1))));

    assert_scanrow_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        disp_active |-> (int'(scan_row) < CELL_H));

    assert_scanrow_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_active && $past(disp_active)) |-> $stable(scan_row));

    assert_hedge_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((hsync_in == hsync_high) && ($past(hsync_in) != $past(hsync_high))) |=> !disp_active);

    assert_vedge_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((vsync_in == vsync_high) && ($past(vsync_in) != $past(vsync_high))) |=> !disp_active);
endmodule

bind cell_raster_addr cra_checker #(
    .COLS(COLS), .ROWS(ROWS), .CELL_W(CELL_W), .CELL_H(CELL_H),
    .ADDR_W(ADDR_W), .DOT_W(DOT_W), .SCAN_W(SCAN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hsync_in   (hsync_in),
    .vsync_in   (vsync_in),
    .hsync_high (hsync_high),
    .vsync_high (vsync_high),
    .disp_active(disp_active),
    .ram_addr   (ram_addr),
    .dot_col    (dot_col),
    .scan_row   (scan_row)
);

// File: tb/cell_raster_addr_bench.sv
module cell_raster_addr_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic       hsync_in, vsync_in, hsync_high, vsync_high;
    logic [9:0] h_start, v_start;
    logic [1:0] h_size, v_size;
    logic [2:0] row_gap_mode;
    logic       disp_active;
    logic [8:0] ram_addr;
    logic [3:0] dot_col;
    logic [4:0] scan_row;

    int n_checks = 0;
    int n_errors = 0;

    localparam int SHORT_LEN = 36;

    // Fields: h_start(10) h_size(2) v_start(10) v_size(2) gap(3) hpol(1) vpol(1) probe cycle(6)
    localparam logic [34:0] VECS [8] = '{
        {10'd1,  2'd0, 10'd1, 2'd0, 3'd0, 1'b1, 1'b1, 6'd7},
        {10'd3,  2'd1, 10'd5, 2'd0, 3'd1, 1'b0, 1'b0, 6'd20},
        {10'd10, 2'd2, 10'd2, 2'd1, 3'd2, 1'b1, 1'b0, 6'd30},
        {10'd1,  2'd3, 10'd3, 2'd0, 3'd3, 1'b0, 1'b1, 6'd33},
        {10'd22, 2'd0, 10'd1, 2'd0, 3'd4, 1'b1, 1'b1, 6'd33},
        {10'd24, 2'd1, 10'd4, 2'd2, 3'd5, 1'b1, 1'b1, 6'd33},
        {10'd2,  2'd0, 10'd2, 2'd0, 3'd6, 1'b0, 1'b1, 6'd9},
        {10'd5,  2'd2, 10'd1, 2'd3, 3'd7, 1'b1, 1'b0, 6'd25}
    };

    cell_raster_addr u_cell_raster_addr (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .hsync_high(hsync_high), .vsync_high(vsync_high),
        .h_start(h_start), .h_size(h_size), .v_start(v_start), .v_size(v_size),
        .row_gap_mode(row_gap_mode), .disp_active(disp_active), .ram_addr(ram_addr),
        .dot_col(dot_col), .scan_row(scan_row)
    );

    // R8 gap table: bands after `done` completed rows
    function automatic int bands_after(input int code, input int done);
        if (code >= 1 && code <= 5) return (done == code || done == 12 - code) ? 1 : 0;
        if (code == 6) return (done == 6) ? 1 : 0;
        if (code == 7) return (done == 6) ? 2 : 0;
        return 0;
    endfunction

    function automatic int total_bands(input int code);
        int t = 0;
        for (int r = 1; r < 12; r++) t += bands_after(code, r);
        return t;
    endfunction

    // kind: 1 text row, 0 gap band, -1 beyond the last row
    task automatic block_kind(input int code, input int blk, output int kind, output int row);
        int b = 0;
        kind = -1;
        row  = 0;
        for (int r = 0; r < 12; r++) begin
            int g;
            if (b == blk) begin kind = 1; row = r; return; end
            b++;
            g = (r == 11) ? 0 : bands_after(code, r + 1);
            if (blk >= b && blk < b + g) begin kind = 0; return; end
            b += g;
        end
    endtask

    task automatic expect_at(input logic [34:0] v, input int n, input int k, output string tag,
                             output logic ea, output int eaddr, output int edc, output int esr);
        int hs, hz, vs, vz, sp, hst, hmul, vmul, hh, y, kind, row, x;
        hs = int'(v[34:25]); hz = int'(v[24:23]); vs = int'(v[22:13]);
        vz = int'(v[12:11]); sp = int'(v[10:8]);
        hst = hs + 6 + hz; hmul = hz + 1; vmul = vz + 1; hh = 18 * vmul;
        ea = 1'b0; eaddr = 0; edc = 0; esr = 0;
        if (n < vs) begin tag = "R5 before vertical start"; return; end
        y = n - vs;
        block_kind(sp, y / hh, kind, row);
        if (kind == 0) begin tag = "R8 R9 gap band"; return; end
        if (kind < 0) begin tag = "R9 past last row"; return; end
        if (k < hst) begin tag = "R3 before horizontal start"; return; end
        x = k - hst;
        if (x >= 288 * hmul) begin tag = "R4 past line end"; return; end
        tag   = "R4 R6 R7 text cell";
        ea    = 1'b1;
        edc   = (x / hmul) % 12;
        esr   = (y % hh) / vmul;
        eaddr = row * 24 + x / (12 * hmul);
    endtask

    task automatic check_pt(input string tag, input logic ea, input int eaddr, input int edc, input int esr);
        n_checks++;
        if (disp_active !== ea || int'(ram_addr) != eaddr || int'(dot_col) != edc || int'(scan_row) != esr) begin
            n_errors++;
            $display("FAIL %s: got act=%0b addr=%0d col=%0d row=%0d, expected act=%0b addr=%0d col=%0d row=%0d",
                     tag, disp_active, ram_addr, dot_col, scan_row, ea, eaddr, edc, esr);
        end
    endtask

    // Starts and ends at a falling clock edge.
    task automatic run_frame(input logic [34:0] v, input int width, input int max_lines, input string ctx);
        int hs, hz, vs, vz, sp, kk, hst, hmul, hh, nlines;
        logic ph, pv;
        hs = int'(v[34:25]); hz = int'(v[24:23]); vs = int'(v[22:13]);
        vz = int'(v[12:11]); sp = int'(v[10:8]); ph = v[7]; pv = v[6]; kk = int'(v[5:0]);
        hst = hs + 6 + hz; hmul = hz + 1; hh = 18 * (vz + 1);
        h_start = v[34:25]; h_size = v[24:23]; v_start = v[22:13]; v_size = v[12:11];
        row_gap_mode = v[10:8]; hsync_high = ph; vsync_high = pv;
        hsync_in = ~ph; vsync_in = ~pv;
        repeat (3) @(negedge clk);
        vsync_in = pv;
        @(negedge clk);
        vsync_in = ~pv;
        repeat (2) @(negedge clk);
        nlines = vs + (12 + total_bands(sp)) * hh + 1;
        if (max_lines > 0 && max_lines < nlines) nlines = max_lines;
        for (int n = 1; n <= nlines; n++) begin
            int  len;
            bit  all;
            all = (n == vs);
            len = all ? hst + 288 * hmul + 4 : SHORT_LEN;
            hsync_in = ph;
            for (int j = 0; j < len; j++) begin
                @(negedge clk);
                if (j + 1 >= width) hsync_in = ~ph;
                if (all || j == kk) begin
                    string tag;
                    logic  ea;
                    int    eaddr, edc, esr;
                    expect_at(v, n, j, tag, ea, eaddr, edc, esr);
                    check_pt({ctx, " ", tag}, ea, eaddr, edc, esr);
                end
            end
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got no completion, expected completion within the cycle limit");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        hsync_high = 1'b1; vsync_high = 1'b1; hsync_in = 1'b0; vsync_in = 1'b0;
        h_start = 10'd1; v_start = 10'd1; h_size = '0; v_size = '0; row_gap_mode = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_pt("R1 reset state", 1'b0, 0, 0, 0);
        repeat (20) @(negedge clk);
        check_pt("R1 idle after reset", 1'b0, 0, 0, 0);

        // Vector walk: all gap codes, size codes and polarities
        for (int i = 0; i < 8; i++) begin
            run_frame(VECS[i], 1, 0, "vector");
        end

        // R2: a sync held asserted for several cycles counts only once
        run_frame(VECS[0], 5, 2, "R2 wide pulse");
        run_frame(VECS[3], 7, 4, "R2 wide pulse inverted");

        // R10: restart in the middle of a frame returns to row 0
        run_frame(VECS[4], 1, 40, "R10 partial frame");
        run_frame(VECS[4], 1, 3, "R10 restart");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule